// File: doc/BRIEF.md
# Bus Access Visibility Encoder

This block lets a logic analyser follow the internal processor bus from the chip's pins. Once per bus cycle it takes the internal access: its source, direction, address, write data, read data, width, byte offset, an error flag and a flag for debug-firmware traffic. It then drives a set of debug pins that are timed against a generated external clock. The pins are a 3-bit access-source code, a read/write line, a low-byte strobe, a shared address/read-data bus and a separate write-data bus.

Each bus cycle takes two core clocks. In the high phase of the external clock the shared lines carry the address. In the low phase they carry the formatted read data for a read, and they keep the address for a write. Visibility is on only in the two emulation modes. In every other mode the pins stay idle. Debug-firmware traffic is hidden as idle cycles. An access stretched over several bus cycles reports its real source in the first cycle and the repeat code in each later cycle.

Top module: `bus_vis_enc`

## Requirements
- R1: The source input takes 00 for processor, 01 for debug port, 10 for coprocessor and 11 for none. A new visible access reports 001 for the processor, 010 for the debug port and 011 for the coprocessor. Source 11 is reported as an idle cycle.
- R2: The source code output is never 110 or 111.
- R3: A cycle with no valid access drives the idle code 100, read/write high (read), strobe low, and zero on both data buses in both phases.
- R4: A processor access flagged as debug firmware is shown exactly as an idle cycle (R3), even when it is a write. The firmware flag has no effect on the other sources.
- R5: A processor access with the error flag set reports 101 and otherwise looks like a normal access. The error flag has no effect on the other sources.
- R6: A write drives read/write low. It puts the address on the shared lines in both phases and the write data on the write-data bus. Reads and idle cycles drive the write-data bus to zero.
- R7: A read drives read/write high. It puts the address on the shared lines in the high phase and the formatted read data in the low phase.
- R8: Read data is big-endian. Bits 15:8 hold the even-address byte and bits 7:0 hold the odd-address byte. A word read shows all 16 bits. A byte read at an even address shows bits 15:8 and zeros bits 7:0. A byte read at an odd address shows bits 7:0 and zeros bits 15:8. The strobe is high for a word access and for a byte access at an odd address, and low for a byte access at an even address.
- R9: A valid cycle with the hold flag, following a visible access or a repeat, reports the repeat code 000. It keeps the previous address, direction, strobe, width and write data. For a read it formats the new read data with the previous width and offset.
- R10: A hold cycle that follows an idle cycle is itself idle.
- R11: Mode bit 1 low (non-emulation modes 00 and 01) forces an idle cycle whatever the other inputs. Modes 10 and 11 make accesses visible.
- R12: The external clock is low during reset and toggles every core clock afterwards. Inputs are sampled at the core clock edge that raises it, and that bus cycle's outputs hold for the following high and low phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode; bit 1 set means emulation |
| in_vld | input | 1 | Access present this bus cycle |
| in_src | input | 2 | Access source (R1 encoding) |
| in_wr | input | 1 | 1 = write |
| in_word | input | 1 | 1 = full word, 0 = single byte |
| in_addr | input | AW | Access address; bit 0 selects the byte |
| in_wdata | input | DW | Write data |
| in_rdata | input | DW | Read data, big-endian lanes |
| in_err | input | 1 | Processor access error |
| in_fw | input | 1 | Processor access to debug firmware or registers |
| in_hold | input | 1 | Continuation cycle of a stretched access |
| vis_eclk | output | 1 | External phase clock |
| vis_acc | output | 3 | Access-source code |
| vis_rw | output | 1 | 1 = read, 0 = write |
| vis_lstrb | output | 1 | Low-byte strobe |
| vis_addr | output | AW | Address / read-data lines |
| vis_wdata | output | DW | Write-data lines |

## Verification
The assertions assume that the inputs are stable across the capture edge at the end of each low phase. They also assume that the source input uses the four R1 values. The bench changes inputs only at a falling core clock edge while the external clock is low, so each value is stable when the next rising edge samples it. The bench sweeps every combination of mode, source, direction, width, offset, error flag and firmware flag. Hold cycles and empty cycles are interleaved, and the source value 11 is driven in a separate pass.

// File: rtl/bus_vis_pkg.sv
package bus_vis_pkg;

  typedef enum logic [2:0] {
    ACC_REPEAT  = 3'b000,
    ACC_CPU     = 3'b001,
    ACC_DBG     = 3'b010,
    ACC_COP     = 3'b011,
    ACC_IDLE    = 3'b100,
    ACC_CPU_ERR = 3'b101
  } acc_e;

  typedef enum logic [1:0] {
    SRC_CPU  = 2'b00,
    SRC_DBG  = 2'b01,
    SRC_COP  = 2'b10,
    SRC_NONE = 2'b11
  } src_e;

endpackage

// File: rtl/bus_vis_rst_sync.sv
module bus_vis_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/bus_vis_phase.sv
module bus_vis_phase (
  input  logic clk,
  input  logic rst_sn,
  output logic eclk,
  output logic cap
);
  // ph_q = 1 : low phase, next edge starts a new bus cycle
  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q <= 1'b1;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign eclk = ~ph_q;
  assign cap  = ph_q;
endmodule

// File: rtl/bus_vis_lane_fmt.sv
module bus_vis_lane_fmt #(
  parameter int DW = 16
) (
  input  logic                        word,
  input  logic [$clog2(DW/8)-1:0]     offs,
  input  logic [DW-1:0]               rdata,
  output logic [DW-1:0]               fmt,
  output logic                        lstrb
);
  localparam int NLANE = DW / 8;
  localparam int LB    = $clog2(NLANE);

  // Lane i (bits 8i+7:8i) holds the byte at offset NLANE-1-i (big-endian)
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic keep;
    always_comb begin
      keep = word || (offs == LB'(NLANE - 1 - i));
      fmt[8*i +: 8] = keep ? rdata[8*i +: 8] : 8'h00;
    end
  end

  always_comb begin
    lstrb = word || (offs == LB'(NLANE - 1));
  end
endmodule

// File: rtl/bus_vis_classify.sv
module bus_vis_classify
  import bus_vis_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          vis_en,
  input  logic          in_vld,
  input  logic [1:0]    in_src,
  input  logic          in_wr,
  input  logic          in_word,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] in_rdata,
  input  logic          in_err,
  input  logic          in_fw,
  input  logic          in_hold,
  input  acc_e          cur_acc,
  input  logic          cur_rw,
  input  logic          cur_lstrb,
  input  logic          cur_word,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_wdata,
  output acc_e          nxt_acc,
  output logic          nxt_rw,
  output logic          nxt_lstrb,
  output logic          nxt_word,
  output logic [AW-1:0] nxt_addr,
  output logic [DW-1:0] nxt_wdata,
  output logic [DW-1:0] nxt_rdat
);
  localparam int LB = $clog2(DW / 8);

  logic          fmt_word;
  logic [LB-1:0] fmt_offs;
  logic [DW-1:0] fmt_data;
  logic          fmt_lstrb;
  logic          is_repeat;
  logic          hidden;
  acc_e          src_code;

  always_comb begin
    is_repeat = in_hold && (cur_acc != ACC_IDLE);
    fmt_word  = is_repeat ? cur_word : in_word;
    fmt_offs  = is_repeat ? cur_addr[LB-1:0] : in_addr[LB-1:0];
  end

  bus_vis_lane_fmt #(.DW(DW)) u_lane (
    .word  (fmt_word),
    .offs  (fmt_offs),
    .rdata (in_rdata),
    .fmt   (fmt_data),
    .lstrb (fmt_lstrb)
  );

  always_comb begin
    hidden = (in_src == SRC_NONE) || ((in_src == SRC_CPU) && in_fw);
    unique case (in_src)
      SRC_CPU: src_code = in_err ? ACC_CPU_ERR : ACC_CPU;
      SRC_DBG: src_code = ACC_DBG;
      SRC_COP: src_code = ACC_COP;
      default: src_code = ACC_IDLE;
    endcase
  end

  always_comb begin
    nxt_acc   = ACC_IDLE;
    nxt_rw    = 1'b1;
    nxt_lstrb = 1'b0;
    nxt_word  = 1'b0;
    nxt_addr  = '0;
    nxt_wdata = '0;
    nxt_rdat  = '0;
    if (vis_en && in_vld) begin
      if (in_hold) begin
        if (is_repeat) begin
          nxt_acc   = ACC_REPEAT;
          nxt_rw    = cur_rw;
          nxt_lstrb = cur_lstrb;
          nxt_word  = cur_word;
          nxt_addr  = cur_addr;
          nxt_wdata = cur_wdata;
          nxt_rdat  = cur_rw ? fmt_data : '0;
        end
      end else if (!hidden) begin
        nxt_acc   = src_code;
        nxt_rw    = ~in_wr;
        nxt_lstrb = fmt_lstrb;
        nxt_word  = in_word;
        nxt_addr  = in_addr;
        nxt_wdata = in_wr ? in_wdata : '0;
        nxt_rdat  = in_wr ? '0 : fmt_data;
      end
    end
  end
endmodule

// File: rtl/bus_vis_enc.sv
module bus_vis_enc
  import bus_vis_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_vld,
  input  logic [1:0]    in_src,
  input  logic          in_wr,
  input  logic          in_word,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] in_rdata,
  input  logic          in_err,
  input  logic          in_fw,
  input  logic          in_hold,
  output logic          vis_eclk,
  output logic [2:0]    vis_acc,
  output logic          vis_rw,
  output logic          vis_lstrb,
  output logic [AW-1:0] vis_addr,
  output logic [DW-1:0] vis_wdata
);
  logic rst_sn;
  logic cap;
  logic vis_en;

  acc_e          acc_q,   acc_d;
  logic          rw_q,    rw_d;
  logic          lstrb_q, lstrb_d;
  logic          word_q,  word_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [DW-1:0] wdat_q,  wdat_d;
  logic [DW-1:0] rdat_q,  rdat_d;

  bus_vis_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  bus_vis_phase u_phase (
    .clk    (clk),
    .rst_sn (rst_sn),
    .eclk   (vis_eclk),
    .cap    (cap)
  );

  assign vis_en = mode[1];

  bus_vis_classify #(.AW(AW), .DW(DW)) u_cls (
    .vis_en    (vis_en),
    .in_vld    (in_vld),
    .in_src    (in_src),
    .in_wr     (in_wr),
    .in_word   (in_word),
    .in_addr   (in_addr),
    .in_wdata  (in_wdata),
    .in_rdata  (in_rdata),
    .in_err    (in_err),
    .in_fw     (in_fw),
    .in_hold   (in_hold),
    .cur_acc   (acc_q),
    .cur_rw    (rw_q),
    .cur_lstrb (lstrb_q),
    .cur_word  (word_q),
    .cur_addr  (addr_q),
    .cur_wdata (wdat_q),
    .nxt_acc   (acc_d),
    .nxt_rw    (rw_d),
    .nxt_lstrb (lstrb_d),
    .nxt_word  (word_d),
    .nxt_addr  (addr_d),
    .nxt_wdata (wdat_d),
    .nxt_rdat  (rdat_d)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q   <= ACC_IDLE;
      rw_q    <= 1'b1;
      lstrb_q <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
    end else if (cap) begin
      acc_q   <= acc_d;
      rw_q    <= rw_d;
      lstrb_q <= lstrb_d;
      word_q  <= word_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
    end
  end

  always_comb begin
    vis_acc   = acc_q;
    vis_rw    = rw_q;
    vis_lstrb = lstrb_q;
    vis_wdata = wdat_q;
    if (!vis_eclk && rw_q) begin
      vis_addr = AW'(rdat_q);
    end else begin
      vis_addr = addr_q;
    end
  end

  AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_sn)
    vis_acc != 3'b110 && vis_acc != 3'b111);  // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    vis_acc == ACC_IDLE |-> vis_rw && !vis_lstrb && vis_addr == '0 && vis_wdata == '0);  // R3

  AST_COP_CODE: assert property (@(posedge clk) disable iff (!rst_sn)
    cap && vis_en && in_vld && !in_hold && in_src == SRC_COP |=> vis_acc == ACC_COP);  // R1

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    cap && !mode[1] |=> vis_acc == ACC_IDLE);  // R11

  AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_sn)
    !vis_eclk && !vis_rw |-> $stable(vis_addr));  // R6

  AST_RD_NO_WDATA: assert property (@(posedge clk) disable iff (!rst_sn)
    vis_rw |-> vis_wdata == '0);  // R6

  AST_REPEAT_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(vis_eclk) && vis_acc == ACC_REPEAT |-> vis_rw == $past(vis_rw));  // R9
endmodule

// File: tb/bus_vis_enc_tb.sv
`timescale 1ns/1ps
module bus_vis_enc_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  mode;
  logic        in_vld;
  logic [1:0]  in_src;
  logic        in_wr;
  logic        in_word;
  logic [15:0] in_addr;
  logic [15:0] in_wdata;
  logic [15:0] in_rdata;
  logic        in_err;
  logic        in_fw;
  logic        in_hold;
  logic        vis_eclk;
  logic [2:0]  vis_acc;
  logic        vis_rw;
  logic        vis_lstrb;
  logic [15:0] vis_addr;
  logic [15:0] vis_wdata;

  int n_tests;
  int n_fail;
  bit done;

  // expectation model state (previous bus cycle)
  logic [2:0]  p_acc;
  logic        p_rw, p_ls, p_word;
  logic [15:0] p_addr, p_wd, p_rd;

  bus_vis_enc #(.AW(16), .DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_vld(in_vld), .in_src(in_src),
    .in_wr(in_wr), .in_word(in_word), .in_addr(in_addr), .in_wdata(in_wdata),
    .in_rdata(in_rdata), .in_err(in_err), .in_fw(in_fw), .in_hold(in_hold),
    .vis_eclk(vis_eclk), .vis_acc(vis_acc), .vis_rw(vis_rw), .vis_lstrb(vis_lstrb),
    .vis_addr(vis_addr), .vis_wdata(vis_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [38:0] act, input logic [38:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] r, input logic word, input logic a0);
    if (word) return r;
    else if (a0) return r & 16'h00FF;
    else return r & 16'hFF00;
  endfunction

  task automatic model(input logic [1:0] m, input logic vld, input logic [1:0] src,
                       input logic wr, input logic word, input logic [15:0] a,
                       input logic [15:0] wd, input logic [15:0] rd,
                       input logic err, input logic fw, input logic hold);
    logic [2:0] e_acc = 3'd4;
    logic e_rw = 1'b1, e_ls = 1'b0, e_word = 1'b0;
    logic [15:0] e_addr = '0, e_wd = '0, e_rd = '0;
    if (m[1] && vld) begin
      if (hold) begin
        if (p_acc != 3'd4) begin
          e_acc = 3'd0; e_rw = p_rw; e_ls = p_ls; e_word = p_word;
          e_addr = p_addr; e_wd = p_wd;
          e_rd = p_rw ? lanes(rd, p_word, p_addr[0]) : 16'h0;
        end
      end else if (src != 2'd3 && !(src == 2'd0 && fw)) begin
        e_acc  = (src == 2'd0) ? (err ? 3'd5 : 3'd1) : (src == 2'd1 ? 3'd2 : 3'd3);
        e_rw   = ~wr;
        e_ls   = word | a[0];
        e_word = word;
        e_addr = a;
        e_wd   = wr ? wd : 16'h0;
        e_rd   = wr ? 16'h0 : lanes(rd, word, a[0]);
      end
    end
    p_acc = e_acc; p_rw = e_rw; p_ls = e_ls; p_word = e_word;
    p_addr = e_addr; p_wd = e_wd; p_rd = e_rd;
  endtask

  // Called at a falling edge in the low phase; returns at the next such point.
  task automatic access(input logic [1:0] m, input logic vld, input logic [1:0] src,
                        input logic wr, input logic word, input logic [15:0] a,
                        input logic [15:0] wd, input logic [15:0] rd,
                        input logic err, input logic fw, input logic hold, input string tag);
    logic [38:0] exp;
    logic [38:0] act;
    mode = m; in_vld = vld; in_src = src; in_wr = wr; in_word = word; in_addr = a;
    in_wdata = wd; in_rdata = rd; in_err = err; in_fw = fw; in_hold = hold;
    model(m, vld, src, wr, word, a, wd, rd, err, fw, hold);
    @(negedge clk);
    act = {vis_eclk, vis_acc, vis_rw, vis_lstrb, vis_addr, vis_wdata, 1'b0};
    exp = {1'b1, p_acc, p_rw, p_ls, p_addr, p_wd, 1'b0};
    check(act === exp, {tag, " R12 high phase"}, act, exp);
    check(vis_acc[2:1] != 2'b11, "R2 reserved code", {36'h0, vis_acc}, {36'h0, 3'b100});
    @(negedge clk);
    act = {vis_eclk, vis_acc, vis_rw, vis_lstrb, vis_addr, vis_wdata, 1'b0};
    exp = {1'b0, p_acc, p_rw, p_ls, (p_rw ? p_rd : p_addr), p_wd, 1'b0};
    check(act === exp, {tag, " low phase"}, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [38:0] act;
    logic [38:0] exp;
    string tag;
    int idx;
    n_tests = 0; n_fail = 0; done = 0; idx = 0;
    p_acc = 3'd4; p_rw = 1; p_ls = 0; p_word = 0; p_addr = 0; p_wd = 0; p_rd = 0;
    rst_n = 1'b0; mode = 2'b10; in_vld = 0; in_src = 0; in_wr = 0; in_word = 0;
    in_addr = 0; in_wdata = 0; in_rdata = 0; in_err = 0; in_fw = 0; in_hold = 0;
    repeat (3) @(negedge clk);
    act = {vis_eclk, vis_acc, vis_rw, vis_lstrb, vis_addr, vis_wdata, 1'b0};
    exp = {1'b0, 3'b100, 1'b1, 1'b0, 16'h0, 16'h0, 1'b0};
    check(act === exp, "R12 R3 reset state", act, exp);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    while (vis_eclk !== 1'b0) @(negedge clk);

    // full sweep
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 3; s++)
        for (int w = 0; w < 2; w++)
          for (int wd = 0; wd < 2; wd++)
            for (int a0 = 0; a0 < 2; a0++)
              for (int e = 0; e < 2; e++)
                for (int f = 0; f < 2; f++) begin
                  logic [15:0] a, wv, rv;
                  a  = ((16'(idx) * 16'h1357 + 16'h0246) & 16'hFFFE) | 16'(a0);
                  wv = (16'(idx) * 16'h0F1D) ^ 16'hA5C3;
                  rv = 16'(idx) * 16'h02B3 + 16'h5A5A;
                  if (m < 2) tag = "R11";
                  else if (s == 0 && f == 1) tag = "R4";
                  else if (s == 0 && e == 1) tag = "R5";
                  else if (w == 1) tag = "R6 R1";
                  else tag = "R7 R8 R1";
                  access(2'(m), 1'b1, 2'(s), 1'(w), 1'(wd), a, wv, rv, 1'(e), 1'(f), 1'b0, tag);
                  if (idx % 3 == 0)
                    access(2'(m), 1'b1, 2'(s), 1'(~w), 1'(~wd), ~a, ~wv, rv ^ 16'h3C3C, 1'(e), 1'(f), 1'b1,
                           (p_acc == 3'd4) ? "R10" : "R9");
                  if (idx % 5 == 0)
                    access(2'(m), 1'b0, 2'(s), 1'(w), 1'(wd), a, wv, rv, 1'(e), 1'(f), 1'b0, "R3");
                  if (idx % 7 == 0) begin
                    access(2'(m), 1'b1, 2'(s), 1'(w), 1'(wd), a, wv, rv, 1'(e), 1'(f), 1'b1,
                           (p_acc == 3'd4) ? "R10" : "R9");
                    access(2'(m), 1'b1, 2'(s), 1'(w), 1'(wd), a, wv, rv ^ 16'hFFFF, 1'(e), 1'(f), 1'b1,
                           (p_acc == 3'd4) ? "R10" : "R9");
                  end
                  idx++;
                end

    // source value 11 is idle; hold after it is idle too
    for (int k = 0; k < 8; k++) begin
      access(2'b11, 1'b1, 2'd3, 1'(k), 1'(k >> 1), 16'(k * 16'h1111), 16'hBEEF, 16'hCAFE, 1'b0, 1'b0, 1'b0, "R1 R3");
      access(2'b11, 1'b1, 2'd1, 1'b0, 1'b1, 16'h1234, 16'h0, 16'h7788, 1'b0, 1'b0, 1'b1, "R10");
    end

    // debug-firmware write then hold: both idle
    access(2'b10, 1'b1, 2'd0, 1'b1, 1'b1, 16'h4001, 16'h5555, 16'h6666, 1'b0, 1'b1, 1'b0, "R4");
    access(2'b10, 1'b1, 2'd0, 1'b1, 1'b1, 16'h4001, 16'h5555, 16'h6666, 1'b0, 1'b0, 1'b1, "R10");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule